// File: doc/BRIEF.md
# Infrared Return-to-Zero Pulse Formatter

This block sits between the serial output of a UART transmitter and an infrared transceiver. It turns the non-return-to-zero bit stream into return-to-zero pulses. A zero bit becomes one high pulse at the start of its bit time. A one bit leaves the line low. The baud generator of the UART marks the first clock of every bit with a one-cycle strobe, and the formatter samples the data bit on that strobe.

The pulse length is not tied to the bit period. It is a multiple of eight system clocks set by a 4-bit width code, and software picks the code to meet the minimum pulse width of the transceiver. Because the length does not depend on the bit period, the block serves every rate up to 115.2 kbit/s. At a 200 MHz clock a bit at that rate lasts about 1736 clocks, which is far longer than the widest pulse. An enable input gates the whole function. The width code and the enable arrive as plain ports.

Top module: `irda_pulse_fmt`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `irOut` is low on the following clock and no pulse is in progress.
- R2: When `enable` is low, `irOut` is low on the next clock. Any pulse in progress is cancelled, and bit strobes seen while `enable` is low start no pulse.
- R3: A strobe with `enable` high and `txBit` equal to 0 drives `irOut` high from the clock after the strobe.
- R4: A strobe with `txBit` equal to 1 drives `irOut` low from the clock after the strobe, and the line stays low until a later strobe carries a 0.
- R5: With no interruption, a pulse lasts exactly 8 × (`widthCode` + 1) clocks. The 4-bit code gives 8 clocks for 0 and 128 clocks for 15.
- R6: `widthCode` is sampled in the strobe cycle that starts a pulse. Changing it during the pulse does not change that pulse's length.
- R7: A strobe that arrives before a pulse has finished ends that pulse, so a pulse never spans two bit periods. If the new bit is 0, a fresh full-length pulse starts at once and `irOut` stays high.
- R8: `irOut` goes high only on the clock after a strobe with `enable` high and `txBit` equal to 0. Without another strobe there is never a second pulse in the same bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| txBit | input | 1 | Serial data from the UART transmitter |
| bitStrobe | input | 1 | One-cycle marker of the first clock of each bit |
| enable | input | 1 | Formatter enable |
| widthCode | input | 4 | Pulse width code; the width is 8 × (code + 1) clocks |
| irOut | output | 1 | Pulse output to the infrared transceiver |

## Verification
Two events can fall in the same cycle: the natural end of a pulse and the strobe of the next bit. A pulse can also still be running when a new strobe arrives. The bench provokes both cases directly. It sets the bit period equal to the pulse width and to one clock less than the width, and it sends runs of zero bits shorter than a pulse. The random phase mixes bit periods below and above the chosen width. A cycle-accurate reference model in the bench judges every clock. It expects the line to stay high across a zero-after-zero boundary, with a new full-length count, and to drop on the next clock when the new bit is a one.

// File: rtl/irda_pulse_pkg.sv
package irda_pulse_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadPulse;   // start a fresh pulse with the sampled width
    logic clearPulse;  // end the current pulse now
  } pulseCtrl_t;
endpackage

// File: rtl/irda_pulse_ctrl.sv
module irda_pulse_ctrl
  import irda_pulse_pkg::*;
(
  input  logic       txBit,
  input  logic       bitStrobe,
  input  logic       enable,
  input  logic       lastCycle,
  output pulseCtrl_t ctrl
);
  always_comb begin
    ctrl.loadPulse  = enable && bitStrobe && !txBit;
    // a strobe always ends the old pulse; load overrides below in datapath
    ctrl.clearPulse = !enable || bitStrobe || lastCycle;
  end
endmodule

// File: rtl/irda_pulse_dp.sv
module irda_pulse_dp
  import irda_pulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 4,
  parameter int UNIT_CLOCKS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pulseCtrl_t            ctrl,
  input  logic [WIDTH_BITS-1:0] widthCode,
  output logic                  pulseOn,
  output logic                  lastCycle
);
  localparam int MAX_LEN = UNIT_CLOCKS * (2 ** WIDTH_BITS);
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    loadVal = CNT_W'((int'(widthCode) + 1) * UNIT_CLOCKS - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseOn <= 1'b0;
      remain  <= '0;
    end else if (ctrl.loadPulse) begin
      pulseOn <= 1'b1;
      remain  <= loadVal;
    end else if (ctrl.clearPulse) begin
      pulseOn <= 1'b0;
      remain  <= '0;
    end else if (pulseOn) begin
      remain <= remain - 1'b1;
    end
  end

  assign lastCycle = pulseOn && (remain == '0);
endmodule

// File: rtl/irda_pulse_fmt.sv
module irda_pulse_fmt
  import irda_pulse_pkg::*;
#(
  parameter int WIDTH_BITS  = 4,
  parameter int UNIT_CLOCKS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  txBit,
  input  logic                  bitStrobe,
  input  logic                  enable,
  input  logic [WIDTH_BITS-1:0] widthCode,
  output logic                  irOut
);
  pulseCtrl_t ctrl;
  logic       lastCycle;

  irda_pulse_ctrl u_ctrl (
    .txBit(txBit), .bitStrobe(bitStrobe), .enable(enable),
    .lastCycle(lastCycle), .ctrl(ctrl)
  );

  irda_pulse_dp #(.WIDTH_BITS(WIDTH_BITS), .UNIT_CLOCKS(UNIT_CLOCKS)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .widthCode(widthCode),
    .pulseOn(irOut), .lastCycle(lastCycle)
  );
endmodule

// File: rtl/irda_pulse_fmt_chk.sv
module irda_pulse_fmt_chk #(
  parameter int WIDTH_BITS  = 4,
  parameter int UNIT_CLOCKS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  txBit,
  input logic                  bitStrobe,
  input logic                  enable,
  input logic [WIDTH_BITS-1:0] widthCode,
  input logic                  irOut
);
  int lenCnt;
  int lenTarget;

  always_ff @(posedge clk) begin
    if (rst) begin
      lenCnt    <= 0;
      lenTarget <= 0;
    end else if (enable && bitStrobe && !txBit) begin
      lenCnt    <= 1;
      lenTarget <= (int'(widthCode) + 1) * UNIT_CLOCKS;
    end else if (irOut) begin
      lenCnt <= lenCnt + 1;
    end
  end

  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> !irOut);
  // R2
  disable_low_chk: assert property (@(posedge clk) disable iff (rst) !enable |=> !irOut);
  // R3
  zero_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && bitStrobe && !txBit) |=> irOut);
  // R4
  one_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (bitStrobe && txBit) |=> !irOut);
  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irOut) |-> $past(enable && bitStrobe && !txBit));
  // R5
  no_overlong_chk: assert property (@(posedge clk) disable iff (rst)
    irOut |-> (lenCnt <= lenTarget));
  // R5
  full_length_chk: assert property (@(posedge clk) disable iff (rst)
    (irOut && lenCnt < lenTarget && enable && !bitStrobe) |=> irOut);
endmodule

bind irda_pulse_fmt irda_pulse_fmt_chk #(.WIDTH_BITS(WIDTH_BITS), .UNIT_CLOCKS(UNIT_CLOCKS)) u_chk (
  .clk(clk), .rst(rst), .txBit(txBit), .bitStrobe(bitStrobe),
  .enable(enable), .widthCode(widthCode), .irOut(irOut)
);

// File: tb/irda_pulse_fmt_tb.sv
module irda_pulse_fmt_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       txBit = 1'b1;
  logic       bitStrobe = 1'b0;
  logic       enable = 1'b0;
  logic [3:0] widthCode = 4'd0;
  logic       irOut;

  int    checks = 0;
  int    errors = 0;
  string curTag = "";
  bit    expOn = 1'b0;
  int    expRemain = 0;
  int    cycles = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  irda_pulse_fmt u_dut (
    .clk(clk), .rst(rst), .txBit(txBit), .bitStrobe(bitStrobe),
    .enable(enable), .widthCode(widthCode), .irOut(irOut)
  );

  function automatic int pulseLen(input logic [3:0] code);
    return 8 * (int'(code) + 1);
  endfunction

  // Reference model built from the requirements
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      expOn = 1'b0; expRemain = 0;
    end else if (!enable) begin
      expOn = 1'b0; expRemain = 0;
    end else if (bitStrobe && !txBit) begin
      expOn = 1'b1; expRemain = pulseLen(widthCode);
    end else if (bitStrobe) begin
      expOn = 1'b0; expRemain = 0;
    end else if (expOn) begin
      expRemain = expRemain - 1;
      if (expRemain == 0) expOn = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!done && curTag != "") begin
      checks++;
      if (irOut !== expOn) begin
        errors++;
        $display("FAIL %s cycle %0d irOut actual %b expected %b", curTag, cycles, irOut, expOn);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBit(input logic b, input int period);
    @(negedge clk);
    txBit = b; bitStrobe = 1'b1;
    @(negedge clk);
    bitStrobe = 1'b0;
    for (int i = 1; i < period - 1; i++) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000 && !done) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    curTag = "R1";
    idle(4);
    rst = 1'b0;
    enable = 1'b1;
    idle(2);

    curTag = "R3 R5 width 0";
    widthCode = 4'd0;
    sendBit(1'b0, 20); sendBit(1'b0, 20);

    curTag = "R5 width 15";
    widthCode = 4'd15;
    sendBit(1'b0, 140);

    curTag = "R4";
    sendBit(1'b1, 60); sendBit(1'b1, 60);

    curTag = "R6";
    widthCode = 4'd3;
    sendBit(1'b0, 2);
    widthCode = 4'd12;
    idle(60);

    curTag = "R2 cancel";
    widthCode = 4'd7;
    sendBit(1'b0, 10);
    enable = 1'b0;
    idle(5);
    sendBit(1'b0, 20);
    enable = 1'b1;
    idle(5);

    curTag = "R7 collision";
    widthCode = 4'd1;
    sendBit(1'b0, 16); sendBit(1'b0, 16);
    sendBit(1'b0, 15); sendBit(1'b1, 20);
    sendBit(1'b0, 5); sendBit(1'b0, 5); sendBit(1'b1, 30);

    curTag = "R1 mid-pulse reset";
    sendBit(1'b0, 4);
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(3);

    curTag = "R8 random";
    for (int k = 0; k < 400; k++) begin
      widthCode = 4'($urandom_range(0, 15));
      enable = ($urandom_range(0, 19) != 0);
      sendBit(1'($urandom_range(0, 1)), int'($urandom_range(3, 150)));
    end
    enable = 1'b1;
    idle(140);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule